// File: doc/BRIEF.md
# Function-Level Reset Sequencer

This block sequences resets for one physical function (PF) and the virtual functions (VFs) that hang off it in a virtualized I/O endpoint. It takes three kinds of reset: a conventional reset (fundamental or hot), a function-level reset (FLR) aimed at a single VF, and an FLR aimed at the PF. For every function it counts the transactions still in flight. It reports an FLR complete only once the targeted function has drained, and while that FLR waits it refuses new requests from the function.

When a reset completes, the block pulses clear strobes towards the register state. Each kind of reset clears a different set of state. A VF FLR clears only that VF's control state and leaves its routing ID, its BARs and its memory-space enable alone. A PF FLR clears the PF, all of its VFs, the VF address state, and the SR-IOV capability fields (VF enable and VF count). A conventional reset clears all of that and also raises a cold strobe that restores power-on defaults everywhere. A conventional reset aborts any FLR that is still pending, in the same cycle. A PF FLR absorbs any VF FLR that is still pending.

Function index 0 is the PF. Index v (1..NUM_VF) is VF v. Bit v-1 of `vf_flr_req` and of `vf_addr_clr` belongs to VF v.

Top module: `flr_seq`

## Requirements
- R1: After `rst_n` is released, `flr_busy`, `flr_done`, `fn_clr`, `vf_addr_clr`, `iov_clr` and `rst_cold` are all zero, and every function has `req_accept` equal to its `req_issue`.
- R2: Each function keeps an outstanding count. An accepted issue adds one and a completion subtracts one. An issue and a completion in the same cycle leave the count unchanged. A completion while the count is zero is ignored.
- R3: When a function's count is 2^CNT_W-1, further issues from that function get `req_accept` low, so the count never wraps.
- R4: `req_accept[f]` is low while the FLR of function f is pending. For a VF, it is also low while a PF FLR is pending.
- R5: A VF FLR request sets `flr_busy[v]` on the next cycle. `flr_done[v]` is high for one cycle, in the first cycle in which busy is set and the VF's count is zero, and never while that count is nonzero. Busy clears in the following cycle.
- R6: In the cycle in which a VF FLR completes, `fn_clr` has only bit v set. `vf_addr_clr`, `iov_clr` and `rst_cold` stay low, so the VF's routing ID, BARs and memory-space enable are kept.
- R7: A PF FLR completes (`flr_done[0]`) only when the PF count and every VF count are zero (PF_DRAIN_VFS=1). In that cycle `fn_clr` is all ones, `vf_addr_clr` is all ones, `iov_clr` is high and `rst_cold` is low.
- R8: A PF FLR request clears any pending VF FLR on the next cycle, and that VF gets no done pulse of its own. VF FLR requests made while a PF FLR is pending are ignored.
- R9: A conventional reset (`conv_rst`) clears every pending FLR and every count at the next edge, with no `flr_done` for the aborted FLRs. In the following cycle `rst_cold`, `iov_clr`, all of `fn_clr` and all of `vf_addr_clr` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| conv_rst | input | 1 | Conventional reset request, synchronous |
| pf_flr_req | input | 1 | FLR request aimed at the PF |
| vf_flr_req | input | NUM_VF | FLR request per VF, bit v-1 for VF v |
| req_issue | input | NUM_VF+1 | A function wants to issue a transaction, bit 0 for the PF |
| cpl_done | input | NUM_VF+1 | A function's transaction completed |
| req_accept | output | NUM_VF+1 | The issue is accepted and counted |
| flr_busy | output | NUM_VF+1 | An FLR is pending for the function |
| flr_done | output | NUM_VF+1 | One-cycle FLR completion pulse |
| fn_clr | output | NUM_VF+1 | Clear the function's control and interrupt state |
| vf_addr_clr | output | NUM_VF | Clear the VF's BARs and memory-space enable |
| iov_clr | output | 1 | Return the PF's SR-IOV capability fields to their defaults |
| rst_cold | output | 1 | Restore all power-on state |

## Verification
The bench sweeps every function against every outstanding count from zero up to saturation. A design that reported an FLR done before the last completion, or that let the saturated count wrap, would pulse done too early. Completions at a zero count, and issues paired with completions in the same cycle, are aimed at counters that underflow or that mishandle simultaneous updates; either fault moves the done pulse. Other cases target a PF FLR arriving over a pending VF FLR and a conventional reset in the middle of a drain. A design with the wrong priority would emit a stray VF done, keep a VF busy, or leave a stale count that delays the next FLR. The bench also compares the strobe pattern of each reset kind against the others, which catches a VF FLR that wrongly clears address state.

// File: rtl/flr_pkg.sv
package flr_pkg;

   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_FUNC = 2'd1,
      RK_PF   = 2'd2,
      RK_COLD = 2'd3
   } rst_kind_e;

   // strongest reset reaching one function this cycle
   function automatic rst_kind_e classify(input logic cold, input logic pf_done,
                                          input logic own_done);
      if (cold)          return RK_COLD;
      else if (pf_done)  return RK_PF;
      else if (own_done) return RK_FUNC;
      else               return RK_NONE;
   endfunction

endpackage

// File: rtl/flr_txn_cnt.sv
module flr_txn_cnt #(
   parameter int CNT_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   input  logic dec,
   output logic zero,
   output logic full
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr)            cnt_q <= '0;
      else if (inc && !dec)    cnt_q <= cnt_q + CNT_W'(1);
      else if (dec && !inc)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign zero = (cnt_q == '0);
   assign full = (cnt_q == MAXV);
endmodule

// File: rtl/flr_pend.sv
module flr_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic abort,
   input  logic arm,
   input  logic drained,
   output logic busy,
   output logic done
);
   logic pend_q;

   assign busy = pend_q;
   assign done = pend_q & drained & ~abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (abort)  pend_q <= 1'b0;
      else if (done)   pend_q <= arm;
      else             pend_q <= pend_q | arm;
   end
endmodule

// File: rtl/flr_seq.sv
module flr_seq #(
   parameter int NUM_VF       = 4,
   parameter int CNT_W        = 4,
   parameter bit PF_DRAIN_VFS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_rst,
   input  logic              pf_flr_req,
   input  logic [NUM_VF-1:0] vf_flr_req,
   input  logic [NUM_VF:0]   req_issue,
   input  logic [NUM_VF:0]   cpl_done,
   output logic [NUM_VF:0]   req_accept,
   output logic [NUM_VF:0]   flr_busy,
   output logic [NUM_VF:0]   flr_done,
   output logic [NUM_VF:0]   fn_clr,
   output logic [NUM_VF-1:0] vf_addr_clr,
   output logic              iov_clr,
   output logic              rst_cold
);
   import flr_pkg::*;

   localparam int NFN = NUM_VF + 1;

   if (NUM_VF < 1 || NUM_VF > 255) begin : g_bad_nvf
      $error("flr_seq: NUM_VF must lie in 1..255");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cw
      $error("flr_seq: CNT_W must lie in 1..16");
   end

   logic [NFN-1:0] cnt_zero, cnt_full, blocked, abort, arm, drained;
   rst_kind_e      kind [NFN];
   logic           conv_q, pf_drained;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) conv_q <= 1'b0;
      else        conv_q <= conv_rst;
   end

   if (PF_DRAIN_VFS) begin : g_pf_all
      assign pf_drained = &cnt_zero;
   end else begin : g_pf_own
      assign pf_drained = cnt_zero[0];
   end

   assign req_accept = req_issue & ~blocked & ~cnt_full & {NFN{~conv_rst}};
   assign rst_cold   = conv_q;
   assign iov_clr    = (kind[0] == RK_COLD) || (kind[0] == RK_PF);

   for (genvar f = 0; f < NFN; f++) begin : g_fn
      if (f == 0) begin : g_pf
         assign blocked[f] = flr_busy[0];
         assign abort[f]   = conv_rst;
         assign arm[f]     = pf_flr_req;
         assign drained[f] = pf_drained;
      end else begin : g_vf
         assign blocked[f]       = flr_busy[f] | flr_busy[0];
         assign abort[f]         = conv_rst | pf_flr_req | flr_busy[0];
         assign arm[f]           = vf_flr_req[f-1];
         assign drained[f]       = cnt_zero[f];
         assign vf_addr_clr[f-1] = (kind[f] == RK_COLD) || (kind[f] == RK_PF);
      end

      flr_txn_cnt #(.CNT_W(CNT_W)) u_cnt (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (conv_rst),
         .inc  (req_accept[f]),
         .dec  (cpl_done[f] & ~cnt_zero[f]),
         .zero (cnt_zero[f]),
         .full (cnt_full[f])
      );

      flr_pend u_pend (
         .clk    (clk),
         .rst_n  (rst_n),
         .abort  (abort[f]),
         .arm    (arm[f]),
         .drained(drained[f]),
         .busy   (flr_busy[f]),
         .done   (flr_done[f])
      );

      assign kind[f]   = classify(conv_q, flr_done[0], flr_done[f]);
      assign fn_clr[f] = (kind[f] != RK_NONE);
   end
endmodule

// File: rtl/flr_seq_chk.sv
module flr_seq_chk #(
   parameter int NUM_VF       = 4,
   parameter bit PF_DRAIN_VFS = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              conv_rst,
   input logic [NUM_VF:0]   req_accept,
   input logic [NUM_VF:0]   flr_busy,
   input logic [NUM_VF:0]   flr_done,
   input logic [NUM_VF-1:0] vf_addr_clr,
   input logic              iov_clr,
   input logic              rst_cold,
   input logic [NUM_VF:0]   cnt_zero,
   input logic [NUM_VF:0]   cnt_full
);
   for (genvar f = 0; f <= NUM_VF; f++) begin : g_f
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_full[f] |-> !req_accept[f]); // R3
      AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
         flr_busy[f] |-> !req_accept[f]); // R4
      if (f > 0) begin : g_vf
         AST_VF_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
            flr_done[f] |-> cnt_zero[f]); // R5
      end
   end

   if (PF_DRAIN_VFS) begin : g_pf
      AST_PF_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
         flr_done[0] |-> (&cnt_zero)); // R7
   end

   AST_VF_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (vf_addr_clr != '0) |-> (rst_cold || flr_done[0])); // R6
   AST_PF_COVERS_VF: assert property (@(posedge clk) disable iff (!rst_n)
      flr_busy[0] |-> (flr_busy[NUM_VF:1] == '0)); // R8
   AST_CONV_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      conv_rst |=> ((flr_busy == '0) && rst_cold && iov_clr)); // R9
endmodule

bind flr_seq flr_seq_chk #(.NUM_VF(NUM_VF), .PF_DRAIN_VFS(PF_DRAIN_VFS)) u_chk (.*);

// File: tb/flr_seq_test.sv
`timescale 1ns/100ps
module flr_seq_test;
   localparam int NV = 3;
   localparam int CW = 2;
   localparam int NF = NV + 1;
   localparam int MAXC = (1 << CW) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic conv, pflr;
   logic [NV-1:0] vflr;
   logic [NF-1:0] issue, cpl;
   logic [NF-1:0] accept, busy, done, fclr;
   logic [NV-1:0] aclr;
   logic iov, cold;
   int ntot = 0, nbad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   flr_seq #(.NUM_VF(NV), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .conv_rst(conv), .pf_flr_req(pflr),
      .vf_flr_req(vflr), .req_issue(issue), .cpl_done(cpl),
      .req_accept(accept), .flr_busy(busy), .flr_done(done), .fn_clr(fclr),
      .vf_addr_clr(aclr), .iov_clr(iov), .rst_cold(cold));

   task automatic chk(input string tag, input int act, input int exp);
      ntot++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic zero_in();
      issue = '0; cpl = '0; vflr = '0; pflr = 1'b0; conv = 1'b0;
   endtask

   task automatic nxt();
      @(posedge clk); #1; zero_in(); #1;
   endtask

   task automatic flr_to(input int f);
      if (f == 0) pflr = 1'b1; else vflr = NV'(1 << (f - 1));
   endtask

   initial begin
      zero_in();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1; #1;
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 strobes", {fclr, aclr, iov, cold}, 0);
      issue = '1; #1;
      chk("R1 accept", accept, (1 << NF) - 1);
      issue = '0;
      nxt();

      // sweep: every function, every outstanding count
      for (int f = 0; f < NF; f++) begin
         for (int n = 0; n <= MAXC; n++) begin
            for (int k = 0; k < n; k++) begin
               issue = NF'(1 << f); #1;
               chk("R2 accept", accept[f], 1);
               nxt();
            end
            if (n == MAXC) begin
               issue = NF'(1 << f); #1;
               chk("R3 saturated refuse", accept[f], 0);
               nxt();
            end
            flr_to(f);
            nxt();
            chk(f == 0 ? "R7 busy" : "R5 busy", busy, 1 << f);
            if (n > 0) begin
               chk(f == 0 ? "R7 early done" : "R5 early done", done, 0);
               issue = NF'(1 << f); #1;
               chk("R4 refuse while pending", accept[f], 0);
               nxt();
               for (int k = 1; k <= n; k++) begin
                  cpl = NF'(1 << f);
                  nxt();
                  chk(f == 0 ? "R7 done" : "R5 done", done, (k == n) ? (1 << f) : 0);
               end
            end else begin
               chk(f == 0 ? "R7 done" : "R5 done", done, 1 << f);
            end
            if (f == 0) begin
               chk("R7 strobes", {fclr, aclr, iov, cold}, {4'hF, 3'h7, 1'b1, 1'b0});
            end else begin
               chk("R6 strobes", {fclr, aclr, iov, cold}, {4'(1 << f), 3'h0, 1'b0, 1'b0});
            end
            nxt();
            chk("R5 cleared", {busy, done}, 0);
         end
      end

      // R2 completion at zero ignored
      cpl = 4'b0010; nxt();
      issue = 4'b0010; nxt();
      vflr = 3'b001; nxt();
      chk("R2 zero cpl ignored", done, 0);
      cpl = 4'b0010; nxt();
      chk("R2 drain after one", done, 4'b0010);
      nxt();

      // R2 issue and completion in one cycle
      issue = 4'b0010; nxt();
      issue = 4'b0010; cpl = 4'b0010; #1;
      chk("R2 accept with cpl", accept[1], 1);
      nxt();
      vflr = 3'b001; nxt();
      chk("R2 count kept", done, 0);
      cpl = 4'b0010; nxt();
      chk("R2 count kept done", done, 4'b0010);
      nxt();

      // R8 PF FLR covers a pending VF FLR
      issue = 4'b0100; nxt();
      issue = 4'b0100; nxt();
      vflr = 3'b010; nxt();
      chk("R8 vf busy", busy, 4'b0100);
      pflr = 1'b1; nxt();
      chk("R8 absorbed", busy, 4'b0001);
      vflr = 3'b001; issue = 4'b0010; #1;
      chk("R4 vf refused under pf", accept[1], 0);
      nxt();
      chk("R8 vf req ignored", busy, 4'b0001);
      cpl = 4'b0100; nxt();
      chk("R7 waits for vf", done, 0);
      cpl = 4'b0100; nxt();
      chk("R8 only pf done", done, 4'b0001);
      chk("R7 full clear", fclr, 4'hF);
      nxt();
      chk("R8 idle", busy, 0);

      // R9 conventional reset aborts a drain
      issue = 4'b0010; nxt();
      vflr = 3'b001; nxt();
      chk("R9 busy before", busy, 4'b0010);
      conv = 1'b1; #1;
      chk("R9 no done in conv", done, 0);
      nxt();
      chk("R9 busy cleared", busy, 0);
      chk("R9 done", done, 0);
      chk("R9 strobes", {fclr, aclr, iov, cold}, {4'hF, 3'h7, 1'b1, 1'b1});
      nxt();
      chk("R9 strobe one cycle", cold, 0);
      vflr = 3'b001; nxt();
      chk("R9 count cleared", done, 4'b0010);
      nxt();

      finished = 1;
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         ntot++; nbad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", ntot, nbad);
         $finish;
      end
   end
endmodule